// File: doc/BRIEF.md
# Synchronous Serial Port Controller

This block moves words between a parallel host interface and a four-wire clocked serial link. The host pushes words into an 8-entry, 16-bit transmit queue and pops received words from an 8-entry, 16-bit receive queue. Each serial frame carries a programmable number of bits, from 4 to 16. Bits are taken from the low end of each queued word and shifted most significant bit first. Received frames are stored right-justified and zero-filled.

As a master, the block drives the serial clock, an active-low select and the outgoing data line, and it samples the incoming data line. The serial clock comes from the system clock through an even divider. The select stays low for as long as words keep arriving, so frames run back to back, and it is released one serial clock period after the last frame. As a slave, the block synchronises an external serial clock and select into its own clock domain and follows them. Each falling edge of the select starts a frame. Clock idle level (polarity) and capture edge (phase) are chosen by two static inputs and apply in both roles.

Top module: `sync_serial_port`

## Requirements
- R1: Each queue holds 8 words of 16 bits in first-in first-out order. `txFull`/`rxFull` and `txEmpty`/`rxEmpty` report the fill state. A push into a full queue and a pop from an empty queue are ignored.
- R2: The frame length N is `frameBits`, forced up to 4 below 4 and down to 16 above 16. The low N bits of a word are sent most significant first. A received frame appears in bits N-1..0 of `rxData` with the upper bits zero, and a frame has exactly 2N serial clock edges.
- R3: The divider D is `prescale` with bit 0 cleared, and a result below 2 is taken as 2. Each serial clock half period lasts D/2 system clocks.
- R4: When no frame is active, `sclkOut` rests at the level of `cpol`.
- R5: With `cpha`=0, data is captured on the first (leading) edge of each bit and launched on the trailing edge. With `cpha`=1, data is launched on the leading edge and captured on the trailing edge.
- R6: In master mode, `csnOut` falls only when the transmit queue holds a word. It stays low across back-to-back frames and rises D system clocks after the final edge. For a burst of F frames it is therefore low for (2NF+2)·D/2 system clocks.
- R7: In slave mode, a falling `csnIn` starts a frame and `sclkIn`/`sdi` are sampled through synchronisers. An empty transmit queue sends zeros. With `cpha`=0, the next word is fetched at the final trailing edge of a frame, and a later select edge does not fetch it again.
- R8: A frame that completes while the receive queue is full is discarded and sets `overrun`. `overrun` stays set until reset.
- R9: In slave mode, `csnOut` is high and `sclkOut` equals `cpol`.
- R10: After reset, both queues are empty, `overrun` is 0 and `csnOut` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| isMaster | input | 1 | 1 selects the master role, 0 the slave role |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0 captures on the leading edge, 1 on the trailing edge |
| frameBits | input | 5 | Requested frame length in bits |
| prescale | input | 8 | Serial clock divider (even, minimum 2) |
| txData | input | 16 | Word to queue for transmission |
| txPush | input | 1 | Queue `txData` this cycle |
| txFull | output | 1 | Transmit queue full |
| txEmpty | output | 1 | Transmit queue empty |
| rxData | output | 16 | Oldest received word |
| rxPop | input | 1 | Remove the oldest received word |
| rxFull | output | 1 | Receive queue full |
| rxEmpty | output | 1 | Receive queue empty |
| overrun | output | 1 | Sticky flag for a discarded received frame |
| sclkOut | output | 1 | Serial clock driven in master mode |
| csnOut | output | 1 | Active-low select driven in master mode |
| sdo | output | 1 | Outgoing serial data (to the slave as master, to the master as slave) |
| sclkIn | input | 1 | External serial clock in slave mode |
| csnIn | input | 1 | External active-low select in slave mode |
| sdi | input | 1 | Incoming serial data |

## Verification
In master mode the outgoing line is looped back to the incoming one. A table of words is then sent across all four polarity/phase pairs, at frame lengths on both sides of the clamps and at odd, zero and largest divider values. A word that returns intact, a select held low for the expected number of cycles and exactly 2N clock toggles together separate a bad bit order, a bad mask, a wrong clamp, a wrong half-period and a late or early select release. A nine-word burst pushed into a full queue, followed by a frame sent into a full receive queue, separates the dropped push, the back-to-back framing and the sticky discard. In slave mode the bench drives the clock itself and samples the returned line on the edge each phase prescribes. This catches a launch on the wrong edge, a missing zero fill when the queue is empty, and a double fetch across two select periods.

// File: rtl/ssport_pkg.sv
package ssport_pkg;

  // Per-cycle commands from the control to the datapath
  typedef struct packed {
    logic txLoad;     // fetch the next word into the shifter
    logic txShift;    // advance the outgoing shifter by one bit
    logic rxSample;   // shift the incoming bit in
    logic rxCommit;   // this sample completes a frame
    logic sampleBit;  // the incoming bit to shift in
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_TAIL
  } mstate_t;

endpackage

// File: rtl/ssport_fifo.sv
module ssport_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [W-1:0] wrData,
  input  logic         rdEn,
  output logic [W-1:0] rdData,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          doWr, doRd;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doWr   = wrEn && !full;
  assign doRd   = rdEn && !empty;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWr) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doRd) rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      if (doWr && !doRd)      count <= count + 1'b1;
      else if (doRd && !doWr) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/ssport_datapath.sv
module ssport_datapath
  import ssport_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int NB_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [NB_W-1:0]   frameLen,
  input  logic [DATA_W-1:0] txData,
  input  logic              txPush,
  output logic              txFull,
  output logic              txEmpty,
  output logic [DATA_W-1:0] rxData,
  input  logic              rxPop,
  output logic              rxFull,
  output logic              rxEmpty,
  output logic              overrun,
  output logic              sdo
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] txHead, txShiftReg, rxWord, lenMask;
  logic [DATA_W-2:0] rxShiftReg;
  logic [IDX_W-1:0]  msbIdx;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) lenMask[i] = (NB_W'(i) < frameLen);
  end

  assign msbIdx = IDX_W'(frameLen - 1'b1);
  assign sdo    = txShiftReg[msbIdx];
  assign rxWord = {rxShiftReg, strb.sampleBit} & lenMask;

  ssport_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txFifo (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (txPush),
    .wrData (txData),
    .rdEn   (strb.txLoad),
    .rdData (txHead),
    .full   (txFull),
    .empty  (txEmpty)
  );

  ssport_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxFifo (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (strb.rxCommit),
    .wrData (rxWord),
    .rdEn   (rxPop),
    .rdData (rxData),
    .full   (rxFull),
    .empty  (rxEmpty)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShiftReg <= '0;
      rxShiftReg <= '0;
      overrun    <= 1'b0;
    end else begin
      if (strb.txLoad)       txShiftReg <= txEmpty ? '0 : txHead;
      else if (strb.txShift) txShiftReg <= txShiftReg << 1;
      if (strb.rxSample)     rxShiftReg <= {rxShiftReg[DATA_W-3:0], strb.sampleBit};
      if (strb.rxCommit && rxFull) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/ssport_control.sv
module ssport_control
  import ssport_pkg::*;
#(
  parameter int NB_W = 5,
  parameter int PS_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            isMaster,
  input  logic            cpol,
  input  logic            cpha,
  input  logic [NB_W-1:0] frameLen,
  input  logic [PS_W-1:0] prescale,
  input  logic            txEmpty,
  input  logic            sclkIn,
  input  logic            csnIn,
  input  logic            sdi,
  output strobe_t         strb,
  output logic            sclkOut,
  output logic            csnOut
);
  mstate_t         state;
  logic [PS_W-1:0] halfRaw, halfLen, halfCnt;
  logic [PS_W:0]   tailCnt, tailLast;
  logic [NB_W:0]   edgeCnt, edgeLast;
  logic [NB_W-1:0] lastBit, launchCnt, sampleCnt;
  logic            sclkPhase, csnReg, preload;
  logic            sclkMeta, sclkSync, sclkPrev;
  logic            csnMeta, csnSync, csnPrev;
  logic            sdiMeta, sdiSync;
  logic            mEdge, mStart, sEdge, sStart;
  logic            leadEv, trailEv, launchEv, sampleEv, startEv, idleNow;

  // Divider: bit 0 dropped, never below one system clock per half period
  assign halfRaw  = {1'b0, prescale[PS_W-1:1]};
  assign halfLen  = (halfRaw == '0) ? PS_W'(1) : halfRaw;
  assign tailLast = {halfLen, 1'b0} - 1'b1;
  assign edgeLast = {frameLen, 1'b0} - 1'b1;
  assign lastBit  = frameLen - 1'b1;

  assign mEdge  = isMaster && (state == ST_RUN) && (halfCnt == halfLen - 1'b1);
  assign mStart = isMaster && (state == ST_IDLE) && !txEmpty;
  assign sEdge  = !isMaster && !csnSync && (sclkSync != sclkPrev);
  assign sStart = !isMaster && csnPrev && !csnSync;

  always_comb begin
    leadEv   = (mEdge && !sclkPhase) || (sEdge && (sclkPrev == cpol));
    trailEv  = (mEdge && sclkPhase)  || (sEdge && (sclkPrev != cpol));
    launchEv = cpha ? leadEv : trailEv;
    sampleEv = cpha ? trailEv : leadEv;
    startEv  = mStart || sStart;
    idleNow  = isMaster ? (state == ST_IDLE) : csnSync;

    strb.txLoad    = (startEv && !cpha && !(sStart && preload)) ||
                     (launchEv && (launchCnt == '0));
    strb.txShift   = launchEv && (launchCnt != '0);
    strb.rxSample  = sampleEv;
    strb.rxCommit  = sampleEv && (sampleCnt == lastBit);
    strb.sampleBit = isMaster ? sdi : sdiSync;
  end

  assign sclkOut = isMaster ? (cpol ^ sclkPhase) : cpol;
  assign csnOut  = csnReg;

  // Slave-side synchronisers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {sclkMeta, sclkSync, sclkPrev} <= '0;
      {csnMeta, csnSync, csnPrev}    <= '1;
      {sdiMeta, sdiSync}             <= '0;
    end else begin
      {sclkMeta, sclkSync, sclkPrev} <= {sclkIn, sclkMeta, sclkSync};
      {csnMeta, csnSync, csnPrev}    <= {csnIn, csnMeta, csnSync};
      {sdiMeta, sdiSync}             <= {sdi, sdiMeta};
    end
  end

  // Master clock and select generation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      halfCnt   <= '0;
      tailCnt   <= '0;
      edgeCnt   <= '0;
      sclkPhase <= 1'b0;
      csnReg    <= 1'b1;
    end else if (!isMaster) begin
      state     <= ST_IDLE;
      sclkPhase <= 1'b0;
      csnReg    <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          sclkPhase <= 1'b0;
          if (mStart) begin
            state   <= ST_RUN;
            halfCnt <= '0;
            edgeCnt <= '0;
            csnReg  <= 1'b0;
          end
        end
        ST_RUN: begin
          if (mEdge) begin
            halfCnt   <= '0;
            sclkPhase <= !sclkPhase;
            if (edgeCnt == edgeLast) begin
              edgeCnt <= '0;
              if (txEmpty) begin
                state   <= ST_TAIL;
                tailCnt <= '0;
              end
            end else begin
              edgeCnt <= edgeCnt + 1'b1;
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        ST_TAIL: begin
          if (tailCnt == tailLast) begin
            state  <= ST_IDLE;
            csnReg <= 1'b1;
          end else begin
            tailCnt <= tailCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Bit position counters shared by both roles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      launchCnt <= '0;
      sampleCnt <= '0;
      preload   <= 1'b0;
    end else begin
      if (startEv) begin
        launchCnt <= cpha ? '0 : NB_W'(1);
        sampleCnt <= '0;
        preload   <= 1'b0;
      end else if (idleNow) begin
        launchCnt <= '0;
        sampleCnt <= '0;
      end else begin
        if (launchEv) launchCnt <= (launchCnt == lastBit) ? '0 : launchCnt + 1'b1;
        if (sampleEv) sampleCnt <= (sampleCnt == lastBit) ? '0 : sampleCnt + 1'b1;
        if (launchEv && (launchCnt == '0) && !isMaster && !cpha && !txEmpty)
          preload <= 1'b1;
      end
      if (isMaster) preload <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssport_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 8,
  parameter int PS_W     = 8,
  parameter int MIN_BITS = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         isMaster,
  input  logic                         cpol,
  input  logic                         cpha,
  input  logic [$clog2(DATA_W+1)-1:0]  frameBits,
  input  logic [PS_W-1:0]              prescale,
  input  logic [DATA_W-1:0]            txData,
  input  logic                         txPush,
  output logic                         txFull,
  output logic                         txEmpty,
  output logic [DATA_W-1:0]            rxData,
  input  logic                         rxPop,
  output logic                         rxFull,
  output logic                         rxEmpty,
  output logic                         overrun,
  output logic                         sclkOut,
  output logic                         csnOut,
  output logic                         sdo,
  input  logic                         sclkIn,
  input  logic                         csnIn,
  input  logic                         sdi
);
  localparam int NB_W = $clog2(DATA_W + 1);

  logic [NB_W-1:0] frameLen;
  strobe_t         strb;

  assign frameLen = (frameBits < NB_W'(MIN_BITS)) ? NB_W'(MIN_BITS) :
                    (frameBits > NB_W'(DATA_W))   ? NB_W'(DATA_W)   : frameBits;

  ssport_control #(.NB_W(NB_W), .PS_W(PS_W)) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .isMaster (isMaster),
    .cpol     (cpol),
    .cpha     (cpha),
    .frameLen (frameLen),
    .prescale (prescale),
    .txEmpty  (txEmpty),
    .sclkIn   (sclkIn),
    .csnIn    (csnIn),
    .sdi      (sdi),
    .strb     (strb),
    .sclkOut  (sclkOut),
    .csnOut   (csnOut)
  );

  ssport_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .NB_W(NB_W)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .frameLen (frameLen),
    .txData   (txData),
    .txPush   (txPush),
    .txFull   (txFull),
    .txEmpty  (txEmpty),
    .rxData   (rxData),
    .rxPop    (rxPop),
    .rxFull   (rxFull),
    .rxEmpty  (rxEmpty),
    .overrun  (overrun),
    .sdo      (sdo)
  );
endmodule

// File: rtl/ssport_checker.sv
module ssport_checker (
  input logic clk,
  input logic rstN,
  input logic isMaster,
  input logic cpol,
  input logic txEmpty,
  input logic txFull,
  input logic rxEmpty,
  input logic rxFull,
  input logic overrun,
  input logic sclkOut,
  input logic csnOut
);
  AST_TX_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(txEmpty && txFull));  // R1
  AST_RX_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rxEmpty && rxFull));  // R1
  AST_TX_FULL_NOT_DRAINED: assert property (@(posedge clk) disable iff (!rstN)
    txFull |=> !txEmpty);  // R1
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);  // R8
  AST_OVERRUN_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(rxFull));  // R8
  AST_IDLE_CLOCK_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && csnOut) |-> (sclkOut == cpol));  // R4
  AST_SELECT_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csnOut) |-> ($past(isMaster) && !$past(txEmpty)));  // R6
  AST_SLAVE_SELECT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !isMaster |=> csnOut);  // R9
endmodule

bind sync_serial_port ssport_checker u_ssport_checker (
  .clk      (clk),
  .rstN     (rstN),
  .isMaster (isMaster),
  .cpol     (cpol),
  .txEmpty  (txEmpty),
  .txFull   (txFull),
  .rxEmpty  (rxEmpty),
  .rxFull   (rxFull),
  .overrun  (overrun),
  .sclkOut  (sclkOut),
  .csnOut   (csnOut)
);

// File: tb/sync_serial_port_bench.sv
module sync_serial_port_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        isMaster = 1'b0, cpol = 1'b0, cpha = 1'b0;
  logic [4:0]  frameBits = 5'd8;
  logic [7:0]  prescale = 8'd2;
  logic [15:0] txData = '0;
  logic        txPush = 1'b0, rxPop = 1'b0;
  logic        txFull, txEmpty, rxFull, rxEmpty, overrun;
  logic [15:0] rxData;
  logic        sclkOut, csnOut, sdo;
  logic        sclkIn = 1'b0, csnIn = 1'b1, benchSdi = 1'b0;
  logic        sdi;
  int          nChecks = 0, nFails = 0, cyc = 0;

  always #5 clk = !clk;
  assign sdi = isMaster ? sdo : benchSdi;

  sync_serial_port u_sync_serial_port (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .cpol(cpol), .cpha(cpha),
    .frameBits(frameBits), .prescale(prescale), .txData(txData), .txPush(txPush),
    .txFull(txFull), .txEmpty(txEmpty), .rxData(rxData), .rxPop(rxPop),
    .rxFull(rxFull), .rxEmpty(rxEmpty), .overrun(overrun), .sclkOut(sclkOut),
    .csnOut(csnOut), .sdo(sdo), .sclkIn(sclkIn), .csnIn(csnIn), .sdi(sdi)
  );

  typedef struct packed {
    logic       pol;
    logic       pha;
    logic [4:0] bits;
    logic [7:0] ps;
    logic [15:0] word;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 1'b0, 5'd8,  8'd4,   16'h00A5},
    '{1'b0, 1'b1, 5'd16, 8'd2,   16'hBEEF},
    '{1'b1, 1'b0, 5'd4,  8'd7,   16'hFFF9},
    '{1'b1, 1'b1, 5'd12, 8'd10,  16'h1234},
    '{1'b0, 1'b0, 5'd2,  8'd1,   16'h000A},
    '{1'b1, 1'b1, 5'd20, 8'd0,   16'h8001},
    '{1'b0, 1'b1, 5'd5,  8'd255, 16'h0015},
    '{1'b1, 1'b0, 5'd16, 8'd3,   16'h7FFE}
  };

  function automatic int clampBits(input int b);
    return (b < 4) ? 4 : (b > 16) ? 16 : b;
  endfunction

  function automatic int halfOf(input int p);
    int d = p & ~1;
    if (d < 2) d = 2;
    return d / 2;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pushWord(input logic [15:0] w);
    @(negedge clk) txData = w; txPush = 1'b1;
    @(negedge clk) txPush = 1'b0;
  endtask

  task automatic popWord(output logic [15:0] w);
    @(negedge clk) w = rxData; rxPop = 1'b1;
    @(negedge clk) rxPop = 1'b0;
  endtask

  // Counts cycles with select low and clock toggles for one master burst
  task automatic runBurst(output int low, output int tog);
    logic prev;
    int   guard;
    low = 0; tog = 0; guard = 0; prev = sclkOut;
    while (csnOut && guard < 1000) begin @(negedge clk); guard++; end
    while (!csnOut && guard < 20000) begin
      low++;
      if (sclkOut != prev) tog++;
      prev = sclkOut;
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic waitIdle();
    repeat (2) @(negedge clk);
    while (!csnOut) @(negedge clk);
  endtask

  // Bench acts as master towards the block in slave mode; 8 clocks per half
  task automatic spiXfer(input logic pol, input logic pha, input int n,
                         input logic [15:0] din, output logic [15:0] dout,
                         output logic quietOk);
    dout = '0; quietOk = 1'b1;
    @(negedge clk) sclkIn = pol; csnIn = 1'b0;
    if (!pha) benchSdi = din[n-1];
    repeat (8) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (pha) benchSdi = din[n-1-i];
      sclkIn = !pol;
      if (!pha) dout = {dout[14:0], sdo};
      repeat (8) @(negedge clk);
      quietOk &= csnOut && (sclkOut == cpol);
      sclkIn = pol;
      if (pha) dout = {dout[14:0], sdo};
      else if (i < n - 1) benchSdi = din[n-2-i];
      repeat (8) @(negedge clk);
    end
    csnIn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] got, cap;
    logic        quiet;
    int          low, tog, n, h;
    logic [15:0] burst [9];

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10", "txEmpty", int'(txEmpty), 1);
    check("R10", "txFull", int'(txFull), 0);
    check("R10", "rxEmpty", int'(rxEmpty), 1);
    check("R10", "overrun", int'(overrun), 0);
    check("R10", "csnOut", int'(csnOut), 1);

    // Table walk in master mode with loopback: R2 R3 R4 R5 R6
    isMaster = 1'b1;
    foreach (VEC[k]) begin
      @(negedge clk);
      cpol = VEC[k].pol; cpha = VEC[k].pha;
      frameBits = VEC[k].bits; prescale = VEC[k].ps;
      n = clampBits(int'(VEC[k].bits));
      h = halfOf(int'(VEC[k].ps));
      pushWord(VEC[k].word);
      runBurst(low, tog);
      check("R2", $sformatf("vec%0d edges", k), tog, 2 * n);
      check("R3", $sformatf("vec%0d select-low cycles", k), low, (2 * n + 2) * h);
      check("R4", $sformatf("vec%0d idle level", k), int'(sclkOut), int'(VEC[k].pol));
      check("R5", $sformatf("vec%0d rx present", k), int'(rxEmpty), 0);
      popWord(got);
      check("R2", $sformatf("vec%0d looped word", k), int'(got),
            int'(VEC[k].word) & ((1 << n) - 1));
    end

    // R1: fill the queue while idle as slave; the ninth push must be dropped
    isMaster = 1'b0; cpol = 1'b0; cpha = 1'b0; frameBits = 5'd8; prescale = 8'd2;
    for (int i = 0; i < 9; i++) begin
      burst[i] = 16'(8'h11 * (i + 1));
      pushWord(burst[i]);
    end
    check("R1", "txFull after 9 pushes", int'(txFull), 1);
    @(negedge clk) isMaster = 1'b1;
    runBurst(low, tog);
    check("R6", "back-to-back select-low cycles", low, (16 * 8 + 2) * 1);
    check("R1", "rxFull after 8 frames", int'(rxFull), 1);
    check("R1", "no overrun from dropped push", int'(overrun), 0);
    for (int i = 0; i < 8; i++) begin
      popWord(got);
      check("R1", $sformatf("fifo order %0d", i), int'(got), int'(burst[i] & 16'h00FF));
    end
    check("R1", "rxEmpty after drain", int'(rxEmpty), 1);
    popWord(got);
    check("R1", "pop on empty ignored", int'(rxEmpty), 1);

    // R8: frame into a full receive queue is dropped and flagged
    for (int i = 0; i < 8; i++) pushWord(16'(8'h20 + i));
    waitIdle();
    check("R8", "rx full before extra frame", int'(rxFull), 1);
    check("R8", "no overrun yet", int'(overrun), 0);
    pushWord(16'h00EE);
    runBurst(low, tog);
    check("R8", "overrun set", int'(overrun), 1);
    popWord(got);
    check("R8", "oldest word kept", int'(got), 16'h0020);
    check("R8", "overrun sticky after pop", int'(overrun), 1);
    while (!rxEmpty) popWord(got);

    // R7 R9 R5: slave role, bench drives the serial clock
    @(negedge clk) isMaster = 1'b0; cpol = 1'b0; cpha = 1'b0; frameBits = 5'd8;
    pushWord(16'h005A);
    spiXfer(1'b0, 1'b0, 8, 16'h0093, cap, quiet);
    check("R5", "slave cpha0 sent", int'(cap), 16'h005A);
    check("R9", "slave outputs quiet", int'(quiet), 1);
    popWord(got);
    check("R7", "slave cpha0 received", int'(got), 16'h0093);

    @(negedge clk) cpol = 1'b1; cpha = 1'b1; frameBits = 5'd12;
    pushWord(16'h0A5C);
    spiXfer(1'b1, 1'b1, 12, 16'h03E1, cap, quiet);
    check("R5", "slave cpha1 sent", int'(cap), 16'h0A5C);
    check("R9", "slave outputs quiet cpol1", int'(quiet), 1);
    popWord(got);
    check("R7", "slave cpha1 received", int'(got), 16'h03E1);

    @(negedge clk) cpol = 1'b1; cpha = 1'b0; frameBits = 5'd6;
    spiXfer(1'b1, 1'b0, 6, 16'h002D, cap, quiet);
    check("R7", "empty queue sends zeros", int'(cap), 0);
    popWord(got);
    check("R7", "received with empty queue", int'(got), 16'h002D);

    // R7: fetch at final trailing edge is not repeated by the next select
    @(negedge clk) cpol = 1'b0; cpha = 1'b0; frameBits = 5'd8;
    pushWord(16'h00C3);
    pushWord(16'h0096);
    spiXfer(1'b0, 1'b0, 8, 16'h0001, cap, quiet);
    check("R7", "first select word", int'(cap), 16'h00C3);
    spiXfer(1'b0, 1'b0, 8, 16'h0002, cap, quiet);
    check("R7", "second select word", int'(cap), 16'h0096);
    check("R7", "queue drained", int'(txEmpty), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule